// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a per-phase PWM request into two gate enables, one for the high-side switch and one for the low-side switch of a synchronous buck stage. It does not wait a fixed dead time. Each turn-on waits on comparator flags that sense the power stage. The low-side switch waits until the switching node reads below 2 V. The high-side switch waits a fixed delay after the low-side gate reads below 1 V. With reverse inductor current the node may never fall after the high side opens. For that case a watchdog enables the low side once a timeout expires, so the current can recirculate.

Two inputs override the normal sequence, one pair per phase. A crowbar input holds the low side on and the high side off, as needed for overvoltage protection. A kill input turns both switches off for faults. Kill wins when both are asserted. The block holds one independent lane for each phase. The phase offset comes from the PWM requests that drive the lanes. Delays are given in nanoseconds and converted to clock counts when the design is elaborated, with the default clock at 1000 MHz.

Top module: `deadtime_seq`

## Requirements
- R1: While reset is high, and on release from reset, every `hs_on` and `ls_on` bit is 0.
- R2: In any lane, `hs_on` and `ls_on` are never 1 in the same cycle.
- R3: The high side turns off on the first clock edge that samples `pwm_req` low. In normal operation `ls_on` then rises on the first later edge that samples `sw_below_2v` high, which is at least one cycle after `hs_on` falls.
- R4: After the high side turns off, if `sw_below_2v` is never sampled high, `ls_on` rises exactly WD_CYC edges after the edge that dropped `hs_on`. WD_CYC is the ceiling of WDOG_NS*CLK_MHZ/1000.
- R5: The low side turns off on the first edge that samples `pwm_req` high. `hs_on` then rises exactly HS_CYC edges after the first edge that samples `lg_below_1v` high, where HS_CYC is the ceiling of HS_DELAY_NS*CLK_MHZ/1000. If the flag drops again during that delay, the turn-on is not cancelled.
- R6: While `hs_on` is 1, `sw_below_2v` has no effect. The high side stays on and the low side stays off for as long as `pwm_req` stays high.
- R7: From the edge after `crowbar` is sampled high (and `kill` low), `ls_on` is 1 and `hs_on` is 0, whatever `pwm_req` does.
- R8: From the edge after `kill` is sampled high, both enables are 0, even if `crowbar` is also high. Once kill and crowbar are released, a high `pwm_req` starts a normal high-side turn-on.
- R9: If `pwm_req` falls while a high-side turn-on is still pending, the turn-on is abandoned and `hs_on` stays 0.
- R10: Lanes are independent. Bit i of every port belongs to phase i, and two lanes driven with opposite PWM requests hold opposite switches on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_req | input | NPH | High-side request per phase (1 = high side wanted) |
| sw_below_2v | input | NPH | Switching node below 2 V comparator flag |
| lg_below_1v | input | NPH | Low-side gate below 1 V comparator flag |
| crowbar | input | NPH | Overvoltage force: low side on, high side off |
| kill | input | NPH | Fault force: both switches off |
| hs_on | output | NPH | High-side gate enable |
| ls_on | output | NPH | Low-side gate enable |

## Verification
The bench sweeps the cycle at which the node flag arrives after high-side turn-off. The sweep covers every position from immediately to past the watchdog limit. An off-by-one counter, a watchdog that fires early or late, or a design that turns the low side on before the flag would each give the wrong rise cycle. A second sweep moves the arrival of the 1 V gate flag and alternates held and one-cycle pulses. This catches a turn-on delay of the wrong length, or a delay that resets when the flag drops. Further cases hold a stale node flag during the high-side on time and drop the request during a pending turn-on. They also assert crowbar and kill together and drive two lanes in antiphase. A design that ignored priority, leaked between lanes or overlapped the gates would show up at the outputs.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_LS_WAIT = 3'd1,
        ST_LS_ON   = 3'd2,
        ST_HS_WAIT = 3'd3,
        ST_HS_ON   = 3'd4
    } dts_state_e;

    typedef struct packed {
        logic pwm;
        logic sw_lo;
        logic lg_lo;
        logic crowbar;
        logic kill;
    } dts_lane_in_t;

    function automatic int ns_to_cycles(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/dts_cnt.sv
module dts_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic hit,
    output logic busy
);
    import dts_pkg::*;

    localparam int W = cnt_width(LIMIT);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit  = (cnt == TOP);
    assign busy = (cnt != '0);

endmodule

// File: rtl/dts_lane.sv
module dts_lane #(
    parameter int HS_CYC = 30,
    parameter int WD_CYC = 240
) (
    input  logic                  clk,
    input  logic                  rst,
    input  dts_pkg::dts_lane_in_t lane_i,
    output logic                  hs_en,
    output logic                  ls_en
);
    import dts_pkg::*;

    dts_state_e st, nxt;
    logic dly_hit, dly_busy, wd_hit, wd_busy;

    // turn-on delay: starts at first sample of the gate flag, then free-runs
    dts_cnt #(.LIMIT(HS_CYC)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .clr  (st != ST_HS_WAIT),
        .en   (st == ST_HS_WAIT && (lane_i.lg_lo || dly_busy)),
        .hit  (dly_hit),
        .busy (dly_busy)
    );

    // node-never-falls watchdog, counts every cycle spent waiting
    dts_cnt #(.LIMIT(WD_CYC - 1)) u_wd (
        .clk  (clk),
        .rst  (rst),
        .clr  (st != ST_LS_WAIT),
        .en   (st == ST_LS_WAIT),
        .hit  (wd_hit),
        .busy (wd_busy)
    );

    always_comb begin
        nxt = st;
        if (lane_i.kill) begin
            nxt = ST_OFF;
        end else if (lane_i.crowbar) begin
            nxt = ST_LS_ON;
        end else begin
            case (st)
                ST_OFF:     nxt = lane_i.pwm ? ST_HS_WAIT : ST_LS_WAIT;
                ST_LS_WAIT: begin
                    if (lane_i.pwm)                   nxt = ST_HS_WAIT;
                    else if (lane_i.sw_lo || wd_hit)  nxt = ST_LS_ON;
                end
                ST_LS_ON:   if (lane_i.pwm)  nxt = ST_HS_WAIT;
                ST_HS_WAIT: begin
                    if (!lane_i.pwm)  nxt = ST_LS_WAIT;
                    else if (dly_hit) nxt = ST_HS_ON;
                end
                ST_HS_ON:   if (!lane_i.pwm) nxt = ST_LS_WAIT;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_OFF;
        else     st <= nxt;
    end

    assign hs_en = (st == ST_HS_ON);
    assign ls_en = (st == ST_LS_ON);

    logic unused_busy;
    assign unused_busy = wd_busy;

endmodule

// File: rtl/deadtime_seq.sv
module deadtime_seq #(
    parameter int NPH         = 2,
    parameter int CLK_MHZ     = 1000,
    parameter int HS_DELAY_NS = 30,
    parameter int WDOG_NS     = 240
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NPH-1:0] pwm_req,
    input  logic [NPH-1:0] sw_below_2v,
    input  logic [NPH-1:0] lg_below_1v,
    input  logic [NPH-1:0] crowbar,
    input  logic [NPH-1:0] kill,
    output logic [NPH-1:0] hs_on,
    output logic [NPH-1:0] ls_on
);
    import dts_pkg::*;

    localparam int HS_CYC_RAW = ns_to_cycles(HS_DELAY_NS, CLK_MHZ);
    localparam int WD_CYC_RAW = ns_to_cycles(WDOG_NS, CLK_MHZ);
    localparam int HS_CYC     = (HS_CYC_RAW < 1) ? 1 : HS_CYC_RAW;
    localparam int WD_CYC     = (WD_CYC_RAW < 2) ? 2 : WD_CYC_RAW;

    for (genvar g = 0; g < NPH; g++) begin : g_lane
        dts_lane_in_t lin;
        assign lin = '{pwm:     pwm_req[g],
                       sw_lo:   sw_below_2v[g],
                       lg_lo:   lg_below_1v[g],
                       crowbar: crowbar[g],
                       kill:    kill[g]};

        dts_lane #(.HS_CYC(HS_CYC), .WD_CYC(WD_CYC)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .lane_i (lin),
            .hs_en  (hs_on[g]),
            .ls_en  (ls_on[g])
        );
    end

endmodule

// File: rtl/dts_chk.sv
module dts_chk #(
    parameter int NPH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [NPH-1:0] pwm_req,
    input logic [NPH-1:0] crowbar,
    input logic [NPH-1:0] kill,
    input logic [NPH-1:0] hs_on,
    input logic [NPH-1:0] ls_on
);
    for (genvar g = 0; g < NPH; g++) begin : g_chk
        AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
            !(hs_on[g] && ls_on[g])); // R2

        AST_LS_AFTER_HS_GAP: assert property (@(posedge clk) disable iff (rst)
            $rose(ls_on[g]) && !$past(crowbar[g]) |-> !$past(hs_on[g])); // R3

        AST_HS_AFTER_LS_GAP: assert property (@(posedge clk) disable iff (rst)
            $rose(hs_on[g]) |-> !$past(ls_on[g])); // R5

        AST_HS_HOLD: assert property (@(posedge clk) disable iff (rst)
            hs_on[g] && pwm_req[g] && !kill[g] && !crowbar[g] |=> hs_on[g]); // R6

        AST_CROWBAR: assert property (@(posedge clk) disable iff (rst)
            crowbar[g] && !kill[g] |=> ls_on[g] && !hs_on[g]); // R7

        AST_KILL: assert property (@(posedge clk) disable iff (rst)
            kill[g] |=> !ls_on[g] && !hs_on[g]); // R8
    end
endmodule

bind deadtime_seq dts_chk #(.NPH(NPH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pwm_req (pwm_req),
    .crowbar (crowbar),
    .kill    (kill),
    .hs_on   (hs_on),
    .ls_on   (ls_on)
);

// File: tb/sim_deadtime_seq.sv
module sim_deadtime_seq;
    localparam int NPH    = 2;
    localparam int MHZ    = 1000;
    localparam int HS_NS  = 3;
    localparam int WD_NS  = 8;
    localparam int HS_CYC = (HS_NS * MHZ + 999) / 1000;
    localparam int WD_CYC = (WD_NS * MHZ + 999) / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NPH-1:0] pwm_req = '0, sw_below_2v = '0, lg_below_1v = '0;
    logic [NPH-1:0] crowbar = '0, kill = '0;
    logic [NPH-1:0] hs_on, ls_on;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    deadtime_seq #(.NPH(NPH), .CLK_MHZ(MHZ), .HS_DELAY_NS(HS_NS), .WDOG_NS(WD_NS)) u0 (
        .clk(clk), .rst(rst), .pwm_req(pwm_req), .sw_below_2v(sw_below_2v),
        .lg_below_1v(lg_below_1v), .crowbar(crowbar), .kill(kill),
        .hs_on(hs_on), .ls_on(ls_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic go_hs_on();
        sw_below_2v[0] = 1'b0;
        lg_below_1v[0] = 1'b1;
        pwm_req[0]     = 1'b1;
        repeat (HS_CYC + 4) tick();
        chk("R5 lane0 reaches high side", int'(hs_on[0]), 1);
    endtask

    task automatic go_ls_on();
        pwm_req[0]     = 1'b0;
        sw_below_2v[0] = 1'b1;
        lg_below_1v[0] = 1'b0;
        repeat (4) tick();
        chk("R3 lane0 reaches low side", int'(ls_on[0]), 1);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int got, exp;
        kill = 2'b10;  // lane 1 parked off while lane 0 is exercised
        repeat (3) tick();
        chk("R1 hs_on in reset", int'(hs_on), 0);
        chk("R1 ls_on in reset", int'(ls_on), 0);
        rst = 1'b0;
        #1;
        chk("R1 hs_on at release", int'(hs_on), 0);
        chk("R1 ls_on at release", int'(ls_on), 0);

        go_hs_on();

        // R6: stale node flag during high-side on time
        sw_below_2v[0] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R6 hs held with node flag", int'(hs_on[0]), 1);
            chk("R6 ls off with node flag", int'(ls_on[0]), 0);
        end

        // R3 / R4: node flag arrival sweep across the watchdog window
        for (int k = 0; k <= WD_CYC + 2; k++) begin
            go_hs_on();
            pwm_req[0] = 1'b0;
            tick();
            chk("R3 hs off on request drop", int'(hs_on[0]), 0);
            got = -1;
            if (k == 0) sw_below_2v[0] = 1'b1;
            for (int i = 1; i <= WD_CYC + 3; i++) begin
                tick();
                if (ls_on[0] && got < 0) got = i;
                if (hs_on[0] && ls_on[0]) chk("R2 overlap", 1, 0);
                if (k == i) sw_below_2v[0] = 1'b1;
            end
            exp = (k + 1 < WD_CYC) ? k + 1 : WD_CYC;
            if (k + 1 < WD_CYC) chk("R3 low-side rise cycle after node flag", got, exp);
            else                chk("R4 watchdog low-side rise cycle", got, exp);
        end

        // R5: gate flag arrival sweep, odd cases use a one-cycle pulse
        for (int j = 0; j <= 4; j++) begin
            go_ls_on();
            pwm_req[0] = 1'b1;
            tick();
            chk("R5 ls drops on request", int'(ls_on[0]), 0);
            got = -1;
            if (j == 0) lg_below_1v[0] = 1'b1;
            for (int i = 1; i <= j + HS_CYC + 4; i++) begin
                tick();
                if (hs_on[0] && got < 0) got = i;
                if (hs_on[0] && ls_on[0]) chk("R2 overlap", 1, 0);
                if (i == j) lg_below_1v[0] = 1'b1;
                else if ((j % 2 == 1) && i == j + 1) lg_below_1v[0] = 1'b0;
            end
            chk("R5 high-side rise cycle after gate flag", got, j + 1 + HS_CYC);
        end

        // R9: request withdrawn while turn-on pending
        go_ls_on();
        sw_below_2v[0] = 1'b0;
        pwm_req[0] = 1'b1;
        tick();
        tick();
        pwm_req[0] = 1'b0;
        lg_below_1v[0] = 1'b1;
        got = 0;
        for (int i = 0; i < HS_CYC + 4; i++) begin
            tick();
            got = got + int'(hs_on[0]);
        end
        chk("R9 aborted turn-on keeps hs off", got, 0);

        // R7: crowbar from high side, held against request toggling
        go_hs_on();
        crowbar[0] = 1'b1;
        tick();
        chk("R7 crowbar ls", int'(ls_on[0]), 1);
        chk("R7 crowbar hs", int'(hs_on[0]), 0);
        for (int i = 0; i < 4; i++) begin
            pwm_req[0] = ~pwm_req[0];
            tick();
            chk("R7 crowbar held ls", int'(ls_on[0]), 1);
            chk("R7 crowbar held hs", int'(hs_on[0]), 0);
        end

        // R8: kill beats crowbar, then recovery
        kill[0] = 1'b1;
        tick();
        chk("R8 kill over crowbar ls", int'(ls_on[0]), 0);
        chk("R8 kill over crowbar hs", int'(hs_on[0]), 0);
        crowbar[0] = 1'b0;
        kill[0] = 1'b0;
        go_hs_on();
        kill[0] = 1'b1;
        tick();
        chk("R8 kill from high side hs", int'(hs_on[0]), 0);
        chk("R8 kill from high side ls", int'(ls_on[0]), 0);
        chk("R10 parked lane1 hs", int'(hs_on[1]), 0);
        chk("R10 parked lane1 ls", int'(ls_on[1]), 0);

        // R10: antiphase lanes
        kill = 2'b00;
        sw_below_2v = 2'b11;
        lg_below_1v = 2'b11;
        pwm_req = 2'b01;
        repeat (HS_CYC + 5) tick();
        chk("R10 antiphase hs 01", int'(hs_on), 1);
        chk("R10 antiphase ls 10", int'(ls_on), 2);
        pwm_req = 2'b10;
        repeat (HS_CYC + 5) tick();
        chk("R10 antiphase hs 10", int'(hs_on), 2);
        chk("R10 antiphase ls 01", int'(ls_on), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule